// File: doc/BRIEF.md
# Byte-Wide GPIO Port Controller

This block is an eight-pin general-purpose I/O port that a processor reaches over a byte-wide register bus: an address, a write strobe, write data and a registered read data return. For each pin it holds a drive enable, an output level, a pull-resistor enable, a two-bit pin-function code, an interrupt enable, an edge polarity and a sticky event flag. Pin inputs are synchronized through two flops before they are read back or checked for edges.

A selected edge on a pin raises that pin's flag. Software may also raise a flag by writing a 1, and only a written 0 lowers it. A single interrupt line goes high when any pin has both its flag and its enable set. When a pin's pull is enabled, its output bit chooses between pulling up and pulling down. The pin-function code is decoded into primary and secondary alternate-function masks for the pin multiplexer outside this block.

Top module: `gpio_byte_port`

## Requirements
- R1: Registers sit at byte offsets 0x20 pin level, 0x21 output, 0x22 drive enable, 0x23 event flag, 0x24 edge polarity, 0x25 interrupt enable, 0x26 function bit 0, 0x27 pull enable, 0x41 function bit 1; `rd_data` shows, one clock after an address is presented, the register at that address as it stood before that edge, and any other address reads 0x00.
- R2: A drive-enable bit of 1 makes `pin_oe` 1 for that pin (pin is an output) and 0 makes it an input; `pin_oe` and `pin_out` follow a write at the same clock edge.
- R3: Reading offset 0x20 returns the pin levels after a two-flop synchronizer; a write to 0x20 changes nothing.
- R4: The output register reads back the last value written, so read-modify-write works, and reset does not change it.
- R5: Reset clears drive enable, event flags, edge polarity, interrupt enable, both function bits and pull enable.
- R6: An edge-polarity bit of 0 sets the pin's flag on a low-to-high change and 1 sets it on a high-to-low change; the other direction leaves the flag alone. A flag is readable three clocks after the pin changes.
- R7: Writing 1 to a flag bit sets it, writing 0 clears it, and no other event clears it.
- R8: A selected edge detected in the same cycle as a software write of 0 to that flag leaves the flag set.
- R9: `irq` is 1, one clock after the state that causes it, exactly when some pin has both its flag and its interrupt enable at 1.
- R10: `pull_en` equals the pull-enable register and `pull_up` equals pull enable AND output bit, both registered one clock after the registers.
- R11: Per pin the code {function bit 1, function bit 0} gives 00 GPIO, 01 primary (`alt_pri` = 1), 11 secondary (`alt_sec` = 1) and 10 reserved (neither mask set); both masks are registered one clock after the registers.
- R12: No edge is detected during the first three clocks after reset is released, so a pin that is already high at reset sets no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| pin_in | input | 8 | Raw pin levels |
| pin_out | output | 8 | Output levels |
| pin_oe | output | 8 | Per-pin drive enable |
| pull_en | output | 8 | Per-pin pull-resistor enable |
| pull_up | output | 8 | Per-pin pull direction, 1 = up |
| alt_pri | output | 8 | Pins assigned to the primary alternate function |
| alt_sec | output | 8 | Pins assigned to the secondary alternate function |
| irq | output | 1 | Interrupt request |

## Verification
The case that matters is a hardware edge that reaches the flag logic in the very cycle a software write of zero to that flag lands. The bench sets several flags by software, changes one pin and times the clearing write to hit the edge that commits the detected edge, then expects the edge's flag to survive and the others to clear. Random pin patterns spaced far enough apart to be seen one at a time, with random edge polarities, are then checked against a bench model of flag accumulation.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned BUS_AW = 8;

  localparam logic [BUS_AW-1:0] OFS_LEVEL = 8'h20;
  localparam logic [BUS_AW-1:0] OFS_OUT   = 8'h21;
  localparam logic [BUS_AW-1:0] OFS_DRV   = 8'h22;
  localparam logic [BUS_AW-1:0] OFS_FLAG  = 8'h23;
  localparam logic [BUS_AW-1:0] OFS_POL   = 8'h24;
  localparam logic [BUS_AW-1:0] OFS_IEN   = 8'h25;
  localparam logic [BUS_AW-1:0] OFS_FN0   = 8'h26;
  localparam logic [BUS_AW-1:0] OFS_PULL  = 8'h27;
  localparam logic [BUS_AW-1:0] OFS_FN1   = 8'h41;

  typedef enum logic [1:0] {
    FN_GPIO = 2'b00,
    FN_PRI  = 2'b01,
    FN_RSVD = 2'b10,
    FN_SEC  = 2'b11
  } pin_fn_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_raw,
  output logic [W-1:0] level,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  localparam int unsigned ARM_LEN = STAGES + 1;

  logic [W-1:0]       chain [STAGES];
  logic [W-1:0]       prev_q;
  logic [ARM_LEN-1:0] arm_q;
  logic               armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) chain[k] <= '0;
      prev_q <= '0;
      arm_q  <= '0;
    end else begin
      chain[0] <= pin_raw;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
      prev_q <= chain[STAGES-1];
      arm_q  <= {arm_q[ARM_LEN-2:0], 1'b1};
    end
  end

  assign armed = arm_q[ARM_LEN-1];
  assign level = chain[STAGES-1];
  assign rise  = armed ? (level & ~prev_q) : '0;
  assign fall  = armed ? (~level & prev_q) : '0;
endmodule

// File: rtl/gpio_edge_flags.sv
module gpio_edge_flags #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] rise,
  input  logic [W-1:0] fall,
  input  logic [W-1:0] pol,
  input  logic         sw_wr,
  input  logic [W-1:0] sw_data,
  output logic [W-1:0] flag
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic hit;
    logic flag_q;
    assign hit = pol[b] ? fall[b] : rise[b];
    always_ff @(posedge clk) begin
      if (rst)        flag_q <= 1'b0;
      else if (hit)   flag_q <= 1'b1;
      else if (sw_wr) flag_q <= sw_data[b];
    end
    assign flag[b] = flag_q;
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_AW-1:0] addr,
  input  logic              wr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      level,
  input  logic [W-1:0]      flag,
  output logic              flag_wr,
  output logic [W-1:0]      out_q,
  output logic [W-1:0]      drv_q,
  output logic [W-1:0]      pol_q,
  output logic [W-1:0]      ien_q,
  output logic [W-1:0]      fn0_q,
  output logic [W-1:0]      fn1_q,
  output logic [W-1:0]      pull_q,
  output logic [W-1:0]      rdata
);
  assign flag_wr = wr && (addr == OFS_FLAG);

  // output latch keeps its value across reset
  always_ff @(posedge clk) begin
    if (wr && addr == OFS_OUT) out_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_q  <= '0;
      pol_q  <= '0;
      ien_q  <= '0;
      fn0_q  <= '0;
      fn1_q  <= '0;
      pull_q <= '0;
    end else if (wr) begin
      case (addr)
        OFS_DRV:  drv_q  <= wdata;
        OFS_POL:  pol_q  <= wdata;
        OFS_IEN:  ien_q  <= wdata;
        OFS_FN0:  fn0_q  <= wdata;
        OFS_FN1:  fn1_q  <= wdata;
        OFS_PULL: pull_q <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (addr)
        OFS_LEVEL: rdata <= level;
        OFS_OUT:   rdata <= out_q;
        OFS_DRV:   rdata <= drv_q;
        OFS_FLAG:  rdata <= flag;
        OFS_POL:   rdata <= pol_q;
        OFS_IEN:   rdata <= ien_q;
        OFS_FN0:   rdata <= fn0_q;
        OFS_FN1:   rdata <= fn1_q;
        OFS_PULL:  rdata <= pull_q;
        default:   rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_byte_port.sv
module gpio_byte_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned W           = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      rd_data,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe,
  output logic [W-1:0]      pull_en,
  output logic [W-1:0]      pull_up,
  output logic [W-1:0]      alt_pri,
  output logic [W-1:0]      alt_sec,
  output logic              irq
);
  logic [W-1:0] level_w, rise_w, fall_w, flag_w;
  logic [W-1:0] out_w, drv_w, pol_w, ien_w, fn0_w, fn1_w, pull_w;
  logic         flag_wr_w;
  logic [W-1:0] pri_d, sec_d;

  gpio_in_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_raw(pin_in),
    .level(level_w), .rise(rise_w), .fall(fall_w)
  );

  gpio_port_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .level(level_w), .flag(flag_w), .flag_wr(flag_wr_w),
    .out_q(out_w), .drv_q(drv_w), .pol_q(pol_w), .ien_q(ien_w),
    .fn0_q(fn0_w), .fn1_q(fn1_w), .pull_q(pull_w), .rdata(rd_data)
  );

  gpio_edge_flags #(.W(W)) u_flags (
    .clk(clk), .rst(rst), .rise(rise_w), .fall(fall_w), .pol(pol_w),
    .sw_wr(flag_wr_w), .sw_data(bus_wdata), .flag(flag_w)
  );

  for (genvar b = 0; b < W; b++) begin : g_fn
    pin_fn_e code;
    assign code     = pin_fn_e'({fn1_w[b], fn0_w[b]});
    assign pri_d[b] = (code == FN_PRI);
    assign sec_d[b] = (code == FN_SEC);
  end

  assign pin_out = out_w;
  assign pin_oe  = drv_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      pull_en <= '0;
      pull_up <= '0;
      alt_pri <= '0;
      alt_sec <= '0;
      irq     <= 1'b0;
    end else begin
      pull_en <= pull_w;
      pull_up <= pull_w & out_w;
      alt_pri <= pri_d;
      alt_sec <= sec_d;
      irq     <= |(flag_w & ien_w);
    end
  end
endmodule

// File: rtl/gpio_byte_port_chk.sv
module gpio_byte_port_chk
  import gpio_port_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [BUS_AW-1:0] bus_addr,
  input logic              bus_wr,
  input logic [W-1:0]      bus_wdata,
  input logic [W-1:0]      pin_out,
  input logic [W-1:0]      pin_oe,
  input logic [W-1:0]      pull_up,
  input logic              irq,
  input logic [W-1:0]      flags,
  input logic [W-1:0]      ien
);
  // R5
  drv_reset_chk: assert property (@(posedge clk) $past(rst) |-> (pin_oe == '0));

  // R2
  drv_write_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_wr) && !$past(rst) && $past(bus_addr) == OFS_DRV) |-> (pin_oe == $past(bus_wdata)));

  // R4
  out_write_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_wr) && $past(bus_addr) == OFS_OUT) |-> (pin_out == $past(bus_wdata)));

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && |($past(flags) & ~flags)) |-> ($past(bus_wr) && $past(bus_addr) == OFS_FLAG));

  // R9
  irq_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq == |($past(flags) & $past(ien))));

  // R10
  pull_dir_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pull_up & ~$past(pin_out)) == '0));
endmodule

bind gpio_byte_port gpio_byte_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .pin_out(pin_out), .pin_oe(pin_oe), .pull_up(pull_up), .irq(irq),
  .flags(flag_w), .ien(ien_w)
);

// File: tb/tb_gpio_byte_port.sv
module tb_gpio_byte_port;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] rd_data, pin_in, pin_out, pin_oe, pull_en, pull_up, alt_pri, alt_sec;
  logic       irq;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  // bench model of the register contents
  logic [7:0] m_out, m_drv, m_pol, m_ien, m_fn0, m_fn1, m_pull, m_flag, m_pin;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_byte_port dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .pull_en(pull_en), .pull_up(pull_up), .alt_pri(alt_pri), .alt_sec(alt_sec), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
    case (a)
      8'h21: m_out  = d;
      8'h22: m_drv  = d;
      8'h23: m_flag = d;
      8'h24: m_pol  = d;
      8'h25: m_ien  = d;
      8'h26: m_fn0  = d;
      8'h41: m_fn1  = d;
      8'h27: m_pull = d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    @(posedge clk); #1;
    d = rd_data;
  endtask

  task automatic set_pin(input logic [7:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    case (a)
      8'h20: return m_pin;
      8'h21: return m_out;
      8'h22: return m_drv;
      8'h23: return m_flag;
      8'h24: return m_pol;
      8'h25: return m_ien;
      8'h26: return m_fn0;
      8'h41: return m_fn1;
      8'h27: return m_pull;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_flags(input logic [7:0] old_p, input logic [7:0] new_p,
                                           input logic [7:0] pol, input logic [7:0] f);
    logic [7:0] up, dn;
    up = new_p & ~old_p;
    dn = old_p & ~new_p;
    return f | (~pol & up) | (pol & dn);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) tick();
    @(negedge clk);
    rst = 1'b0;
    m_drv = 0; m_pol = 0; m_ien = 0; m_fn0 = 0; m_fn1 = 0; m_pull = 0; m_flag = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    logic [7:0] regs [7];
    void'($urandom(32'd20240611));
    regs[0] = 8'h21; regs[1] = 8'h22; regs[2] = 8'h24; regs[3] = 8'h25;
    regs[4] = 8'h26; regs[5] = 8'h41; regs[6] = 8'h27;

    // R12: pins high through reset must not raise flags
    pin_in = 8'hFF; m_pin = 8'hFF;
    m_out = 8'h00;
    do_reset();
    repeat (6) tick();
    rd(8'h23, v); check("R12 no flag from pins high at reset", v, 8'h00);

    // R5: reset state
    check("R5 pin_oe after reset", pin_oe, 8'h00);
    check("R5 pull_en after reset", pull_en, 8'h00);
    check("R5 alt_pri after reset", alt_pri, 8'h00);
    check("R9 irq after reset", {7'b0, irq}, 8'h00);
    rd(8'h24, v); check("R5 polarity after reset", v, 8'h00);
    rd(8'h25, v); check("R5 enable after reset", v, 8'h00);

    // R4: output register survives reset; read-modify-write
    wr(8'h21, 8'hA5);
    check("R4 pin_out after write", pin_out, 8'hA5);
    wr(8'h22, 8'h3C);
    check("R2 pin_oe after write", pin_oe, 8'h3C);
    do_reset();
    tick();
    rd(8'h21, v); check("R4 output kept through reset", v, 8'hA5);
    check("R4 pin_out kept through reset", pin_out, 8'hA5);
    check("R5 drive cleared by reset", pin_oe, 8'h00);
    rd(8'h21, v); wr(8'h21, v | 8'h02);
    rd(8'h21, v); check("R4 read-modify-write", v, 8'hA7);

    // R3: level register and ignored write
    set_pin(8'h5A); m_pin = 8'h5A;
    repeat (3) tick();
    rd(8'h20, v); check("R3 level readback", v, 8'h5A);
    wr(8'h20, 8'hFF);
    rd(8'h20, v); check("R3 write to level ignored", v, 8'h5A);
    rd(8'h33, v); check("R1 unmapped address reads zero", v, 8'h00);

    // R11: function codes {fn1,fn0}: bit0 00, bit1 01, bit2 10, bit3 11
    wr(8'h26, 8'h0A); wr(8'h41, 8'h0C);
    tick();
    check("R11 primary mask", alt_pri, 8'h02);
    check("R11 secondary mask, reserved code gives neither", alt_sec, 8'h08);

    // R10: pull enable and direction
    wr(8'h21, 8'hF0); wr(8'h27, 8'h3C);
    tick();
    check("R10 pull_en", pull_en, 8'h3C);
    check("R10 pull_up", pull_up, 8'h30);

    // R6: polarity per bit
    set_pin(8'h00); m_pin = 8'h00;
    repeat (5) tick();
    wr(8'h23, 8'h00);
    wr(8'h24, 8'h02);
    set_pin(8'h03);
    repeat (3) tick();
    rd(8'h23, v); check("R6 rising edge flags bit0 only", v, 8'h01);
    set_pin(8'h00);
    repeat (3) tick();
    rd(8'h23, v); check("R6 falling edge flags bit1", v, 8'h03);
    m_flag = 8'h03;

    // R9: interrupt request
    wr(8'h25, 8'h02);
    tick();
    check("R9 irq with enabled flag", {7'b0, irq}, 8'h01);
    wr(8'h25, 8'h04);
    tick();
    check("R9 irq with no enabled flag", {7'b0, irq}, 8'h00);

    // R7: software set and clear
    wr(8'h23, 8'hF0);
    rd(8'h23, v); check("R7 software write of flags", v, 8'hF0);

    // R8: rising edge on bit0 committed at the same edge as a clear write
    wr(8'h24, 8'h00);
    wr(8'h23, 8'h0F);
    set_pin(8'h01);
    repeat (2) tick();
    wr(8'h23, 8'h00);
    rd(8'h23, v); check("R8 edge beats software clear", v, 8'h01);
    check("R7 other flags cleared by write", v & 8'hFE, 8'h00);
    m_pin = 8'h01; m_flag = 8'h01;

    // random configuration writes with readback of random addresses
    for (int i = 0; i < 60; i++) begin
      logic [7:0] a, d, ra;
      a = regs[$urandom_range(0, 6)];
      d = 8'($urandom);
      wr(a, d);
      check("R2 pin_oe follows drive register", pin_oe, m_drv);
      check("R4 pin_out follows output register", pin_out, m_out);
      case ($urandom_range(0, 2))
        0: ra = 8'h20 + 8'($urandom_range(0, 7));
        1: ra = 8'h41;
        default: ra = 8'($urandom);
      endcase
      rd(ra, v); check("R1 readback", v, exp_read(ra));
      check("R10 pull_up random", pull_up, m_pull & m_out);
      check("R11 primary random", alt_pri, m_fn0 & ~m_fn1);
      check("R11 secondary random", alt_sec, m_fn0 & m_fn1);
      check("R9 irq random", {7'b0, irq}, {7'b0, |(m_flag & m_ien)});
    end

    // random pin patterns, spaced so each change is seen alone
    for (int i = 0; i < 40; i++) begin
      logic [7:0] np;
      if (i % 8 == 0) wr(8'h24, 8'($urandom));
      if (i % 5 == 0) wr(8'h23, 8'($urandom));
      np = 8'($urandom);
      m_flag = exp_flags(m_pin, np, m_pol, m_flag);
      m_pin = np;
      set_pin(np);
      repeat (3) tick();
      rd(8'h23, v); check("R6 flag accumulation", v, m_flag);
      rd(8'h20, v); check("R3 level random", v, m_pin);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule